// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Early Branch Flush Unit

This block sits beside the decode stage of a five-stage in-order pipeline and makes two decisions in every cycle. The first is whether the instruction now in decode reads a register that a load, one stage ahead in execute, has not yet brought back from memory. When it does, the unit holds the program counter and the fetch/decode register, so the same instruction is fetched again and the decoded one is kept. It also replaces the control word passed toward execute with all zeros, which turns that slot into a no-op bubble. The dependency is gone one cycle later, because by then the load has reached the memory stage and ordinary forwarding can supply its result.

The second decision settles a branch-if-equal in decode. The unit forms the bitwise difference of the two operands and OR-reduces it. Identical operands mean the branch is taken. Fetch always goes on sequentially by default, so a taken branch costs exactly one slot: the instruction sitting in the fetch/decode register is flushed. If a stall and a taken branch are raised together, the stall wins and no flush is issued, because the branch is decoded again once the stall clears. The datapath itself lies outside the block. The unit is purely combinational, and its outputs follow its inputs within the same cycle.

Top module: `hazard_ctl`

## Requirements
- R1: A stall is raised when `idex_mem_rd` is 1 and `idex_dst` equals `ifid_src_a` or `ifid_src_b`. Register index 0 gets no exemption.
- R2: When `idex_mem_rd` is 0 no stall is raised, whatever the register fields hold.
- R3: During a stall both `pc_wr_en` and `ifid_wr_en` are 0. At all other times both are 1.
- R4: During a stall `bubble_sel` is 1 and `id_ctrl_out` is all zeros. At all other times `bubble_sel` is 0 and `id_ctrl_out` equals `id_ctrl_in`.
- R5: `if_flush` is 1 when `id_is_branch` is 1, `br_op_a` equals `br_op_b`, and no stall is raised.
- R6: `if_flush` is 0 when `id_is_branch` is 0 or the operands differ, so fall-through fetch continues.
- R7: When a stall and a taken branch occur in the same cycle, the stall outputs of R3 and R4 apply and `if_flush` is 0.
- R8: A taken branch on its own does not stall. `pc_wr_en` and `ifid_wr_en` stay 1 so that the target can be loaded.
- R9: Operands that differ in any single bit position, from 0 to DATA_W-1, are treated as unequal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_src_a | input | REG_AW | First source register index of the instruction in decode |
| ifid_src_b | input | REG_AW | Second source register index of the instruction in decode |
| idex_mem_rd | input | 1 | Instruction in execute reads data memory (a load) |
| idex_dst | input | REG_AW | Load target register index of the instruction in execute |
| id_ctrl_in | input | CTRL_W | Control word produced by decode |
| id_is_branch | input | 1 | Instruction in decode is a branch-if-equal |
| br_op_a | input | DATA_W | First branch operand |
| br_op_b | input | DATA_W | Second branch operand |
| pc_wr_en | output | 1 | Program counter update enable |
| ifid_wr_en | output | 1 | Fetch/decode register update enable |
| bubble_sel | output | 1 | Bubble inserted into the control word |
| id_ctrl_out | output | CTRL_W | Control word forwarded toward execute |
| if_flush | output | 1 | Clear the fetch/decode register |

## Verification
The immediate assertions check several relations for every input combination that reaches the block:
- the two hold enables always agree;
- a bubble always carries an all-zero control word;
- no load in execute means no hold;
- a flush never coexists with a hold;
- a flush implies a branch whose operands compare equal.

Other behaviours only the bench scenarios can show. These are the exact matching rule for the register fields, including index 0. They also include the stall-over-branch priority in a concrete cycle, the pass-through of arbitrary control words, and the sensitivity of the compare to a one-bit difference at every bit position.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [0:0] {
      CTRL_PASS   = 1'b0,
      CTRL_BUBBLE = 1'b1
   } ctrl_sel_e;

   localparam int CMP_FLAT    = 0;
   localparam int CMP_GROUPED = 1;

   typedef struct packed {
      logic stall;
      logic take;
   } hz_dec_t;

endpackage

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src_a,
   input  logic [REG_AW-1:0] src_b,
   input  logic              ld_valid,
   input  logic [REG_AW-1:0] ld_dst,
   output logic              stall
);
   logic [1:0] hit;

   always_comb begin
      hit[0] = (ld_dst == src_a);
      hit[1] = (ld_dst == src_b);
      stall  = ld_valid & (|hit);
   end

endmodule

// File: rtl/hzd_br_cmp.sv
module hzd_br_cmp #(
   parameter int DATA_W    = 32,
   parameter int CMP_STYLE = 1,
   parameter int GRP_W     = 8
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              equal
);
   localparam int NGRP  = (DATA_W + GRP_W - 1) / GRP_W;
   localparam int PAD_W = NGRP * GRP_W - DATA_W;

   logic [DATA_W-1:0] diff;
   assign diff = op_a ^ op_b;

   if (CMP_STYLE == hzd_pkg::CMP_FLAT) begin : g_flat
      assign equal = ~(|diff);
   end else begin : g_grouped
      logic [NGRP*GRP_W-1:0] diff_pad;
      logic [NGRP-1:0]       grp_any;
      if (PAD_W > 0) begin : g_pad
         assign diff_pad = {{PAD_W{1'b0}}, diff};
      end else begin : g_nopad
         assign diff_pad = diff;
      end
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp_any[g] = |diff_pad[g*GRP_W +: GRP_W];
      end
      assign equal = ~(|grp_any);
   end

endmodule

// File: rtl/hzd_issue_ctl.sv
module hzd_issue_ctl #(
   parameter int CTRL_W = 9
) (
   input  logic              stall,
   input  logic              is_branch,
   input  logic              ops_equal,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic              pc_wr_en,
   output logic              ifid_wr_en,
   output logic              bubble_sel,
   output logic [CTRL_W-1:0] ctrl_out,
   output logic              flush
);
   import hzd_pkg::*;

   hz_dec_t   dec;
   ctrl_sel_e sel;

   always_comb begin
      dec.stall  = stall;
      dec.take   = is_branch & ops_equal;
      sel        = dec.stall ? CTRL_BUBBLE : CTRL_PASS;
      pc_wr_en   = ~dec.stall;
      ifid_wr_en = ~dec.stall;
      bubble_sel = (sel == CTRL_BUBBLE);
      ctrl_out   = (sel == CTRL_BUBBLE) ? '0 : ctrl_in;
      flush      = dec.take & ~dec.stall;
   end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
   parameter int REG_AW    = 5,
   parameter int DATA_W    = 32,
   parameter int CTRL_W    = 9,
   parameter int CMP_STYLE = 1,
   parameter int GRP_W     = 8
) (
   input  logic [REG_AW-1:0] ifid_src_a,
   input  logic [REG_AW-1:0] ifid_src_b,
   input  logic              idex_mem_rd,
   input  logic [REG_AW-1:0] idex_dst,
   input  logic [CTRL_W-1:0] id_ctrl_in,
   input  logic              id_is_branch,
   input  logic [DATA_W-1:0] br_op_a,
   input  logic [DATA_W-1:0] br_op_b,
   output logic              pc_wr_en,
   output logic              ifid_wr_en,
   output logic              bubble_sel,
   output logic [CTRL_W-1:0] id_ctrl_out,
   output logic              if_flush
);
   if (REG_AW < 1) begin : g_bad_aw
      $error("REG_AW must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be at least 1");
   end
   if (CTRL_W < 1) begin : g_bad_cw
      $error("CTRL_W must be at least 1");
   end
   if (GRP_W < 1 || GRP_W > DATA_W) begin : g_bad_gw
      $error("GRP_W must lie in 1..DATA_W");
   end
   if (CMP_STYLE != hzd_pkg::CMP_FLAT && CMP_STYLE != hzd_pkg::CMP_GROUPED) begin : g_bad_cs
      $error("CMP_STYLE must be 0 or 1");
   end

   logic ld_stall;
   logic ops_equal;

   hzd_load_use #(.REG_AW(REG_AW)) u_load_use (
      .src_a    (ifid_src_a),
      .src_b    (ifid_src_b),
      .ld_valid (idex_mem_rd),
      .ld_dst   (idex_dst),
      .stall    (ld_stall)
   );

   hzd_br_cmp #(.DATA_W(DATA_W), .CMP_STYLE(CMP_STYLE), .GRP_W(GRP_W)) u_br_cmp (
      .op_a  (br_op_a),
      .op_b  (br_op_b),
      .equal (ops_equal)
   );

   hzd_issue_ctl #(.CTRL_W(CTRL_W)) u_issue (
      .stall      (ld_stall),
      .is_branch  (id_is_branch),
      .ops_equal  (ops_equal),
      .ctrl_in    (id_ctrl_in),
      .pc_wr_en   (pc_wr_en),
      .ifid_wr_en (ifid_wr_en),
      .bubble_sel (bubble_sel),
      .ctrl_out   (id_ctrl_out),
      .flush      (if_flush)
   );

   always_comb begin
      AST_HOLD_PAIRED: assert (pc_wr_en == ifid_wr_en); // R3
      if (bubble_sel) begin
         AST_BUBBLE_ZERO: assert (id_ctrl_out == '0); // R4
      end
      if (!idex_mem_rd) begin
         AST_NO_LOAD_NO_HOLD: assert (pc_wr_en); // R2
      end
      if (if_flush) begin
         AST_FLUSH_NOT_HELD: assert (pc_wr_en && !bubble_sel); // R7
         AST_FLUSH_NEEDS_EQ: assert (id_is_branch && (br_op_a == br_op_b)); // R5
      end
   end

endmodule

// File: tb/hazard_ctl_bench.sv
module hazard_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int CW = 9;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0] src_a, src_b, dst;
   logic          mem_rd, is_br;
   logic [CW-1:0] ctrl_in;
   logic [DW-1:0] op_a, op_b;
   logic          pc_wr, ifid_wr, bub, flush;
   logic [CW-1:0] ctrl_out;

   hazard_ctl u_hazard_ctl (
      .ifid_src_a   (src_a),
      .ifid_src_b   (src_b),
      .idex_mem_rd  (mem_rd),
      .idex_dst     (dst),
      .id_ctrl_in   (ctrl_in),
      .id_is_branch (is_br),
      .br_op_a      (op_a),
      .br_op_b      (op_b),
      .pc_wr_en     (pc_wr),
      .ifid_wr_en   (ifid_wr),
      .bubble_sel   (bub),
      .id_ctrl_out  (ctrl_out),
      .if_flush     (flush)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic m,
                        input logic [AW-1:0] d, input logic br, input logic [DW-1:0] x,
                        input logic [DW-1:0] y, input logic [CW-1:0] c);
      @(negedge clk);
      src_a = a; src_b = b; mem_rd = m; dst = d;
      is_br = br; op_a = x; op_b = y; ctrl_in = c;
      #(CLK_PERIOD/4);
   endtask

   task automatic chk_out(input string req, input logic e_stall, input logic e_flush);
      chk({req, " pc_wr_en"},   {63'd0, pc_wr},   {63'd0, ~e_stall});
      chk({req, " ifid_wr_en"}, {63'd0, ifid_wr}, {63'd0, ~e_stall});
      chk({req, " bubble_sel"}, {63'd0, bub},     {63'd0, e_stall});
      chk({req, " ctrl_out"},   {55'd0, ctrl_out}, e_stall ? 64'd0 : {55'd0, ctrl_in});
      chk({req, " if_flush"},   {63'd0, flush},   {63'd0, e_flush});
   endtask

   typedef struct packed {
      logic [AW-1:0] sa;
      logic [AW-1:0] sb;
      logic          mr;
      logic [AW-1:0] d;
      logic          br;
      logic [DW-1:0] a;
      logic [DW-1:0] b;
      logic [CW-1:0] c;
      logic          e_stall;
      logic          e_flush;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{5'd1,  5'd2,  1'b0, 5'd1,  1'b0, 32'h0,        32'h0,        9'h1A5, 1'b0, 1'b0}, // R2 match but no load
      '{5'd3,  5'd9,  1'b1, 5'd3,  1'b0, 32'h0,        32'h1,        9'h0FF, 1'b1, 1'b0}, // R1 first source
      '{5'd8,  5'd4,  1'b1, 5'd4,  1'b0, 32'h0,        32'h1,        9'h155, 1'b1, 1'b0}, // R1 second source
      '{5'd6,  5'd7,  1'b1, 5'd5,  1'b0, 32'h0,        32'h0,        9'h0AA, 1'b0, 1'b0}, // R1 no match
      '{5'd0,  5'd0,  1'b1, 5'd0,  1'b0, 32'h0,        32'h0,        9'h1FF, 1'b1, 1'b0}, // R1 index 0
      '{5'd1,  5'd2,  1'b0, 5'd0,  1'b1, 32'h1234ABCD, 32'h1234ABCD, 9'h033, 1'b0, 1'b1}, // R5 R8 taken
      '{5'd1,  5'd2,  1'b0, 5'd0,  1'b1, 32'h1234ABCD, 32'h1234ABCC, 9'h033, 1'b0, 1'b0}, // R6 unequal
      '{5'd1,  5'd2,  1'b0, 5'd0,  1'b0, 32'h55,       32'h55,       9'h077, 1'b0, 1'b0}, // R6 not a branch
      '{5'd4,  5'd11, 1'b1, 5'd11, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 9'h1C3, 1'b1, 1'b0}, // R7 stall wins
      '{5'd4,  5'd11, 1'b1, 5'd12, 1'b1, 32'h80000000, 32'h80000000, 9'h101, 1'b0, 1'b1}, // R8 load no match, taken
      '{5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 32'h0,        32'h0,        9'h100, 1'b1, 1'b0}  // R7 top index
   };

   initial begin
      src_a = '0; src_b = '0; mem_rd = 1'b0; dst = '0;
      is_br = 1'b0; op_a = '0; op_b = '0; ctrl_in = '0;
      #(CLK_PERIOD/4);
      // idle state after start: no hold, no bubble, no flush
      chk("R3 idle pc_wr_en", {63'd0, pc_wr}, 64'd1);
      chk("R6 idle if_flush", {63'd0, flush}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].sa, VEC[i].sb, VEC[i].mr, VEC[i].d, VEC[i].br, VEC[i].a, VEC[i].b, VEC[i].c);
         chk_out("R1 R3 R4 R5 vector", VEC[i].e_stall, VEC[i].e_flush);
      end

      // R9: one differing bit anywhere makes the branch not taken
      for (int k = 0; k < DW; k++) begin
         apply(5'd1, 5'd2, 1'b0, 5'd3, 1'b1, 32'hA5A5_5A5A, 32'hA5A5_5A5A ^ (32'd1 << k), 9'h011);
         chk("R9 single-bit difference", {63'd0, flush}, 64'd0);
      end

      // R4: pass-through of distinct control words when not stalled
      for (int k = 0; k < CW; k++) begin
         apply(5'd1, 5'd2, 1'b1, 5'd3, 1'b0, 32'h0, 32'h1, 9'd1 << k);
         chk("R4 ctrl pass", {55'd0, ctrl_out}, {55'd0, 9'd1 << k});
      end

      // R2: no load, every field equal, still no hold
      apply(5'd17, 5'd17, 1'b0, 5'd17, 1'b0, 32'h0, 32'h1, 9'h1FF);
      chk_out("R2 all fields match", 1'b0, 1'b0);

      // R7 then release: branch re-evaluated after the stall clears
      apply(5'd9, 5'd2, 1'b1, 5'd9, 1'b1, 32'h7, 32'h7, 9'h0F0);
      chk_out("R7 stall with branch", 1'b1, 1'b0);
      apply(5'd9, 5'd2, 1'b0, 5'd9, 1'b1, 32'h7, 32'h7, 9'h0F0);
      chk_out("R5 branch after stall", 1'b0, 1'b1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule